// File: doc/BRIEF.md
# Double-Word Flash Program Controller

This block sits between a 32-bit bus and a flash array that can only be written one 64-bit double-word at a time. Software sets a program-enable bit in a control register. After that, word writes into the flash window are treated as program data. The block pairs two such writes into one 64-bit value. Before it starts a program cycle, it checks the shape of each write, whether the target page is locked and whether the target double-word is still blank.

A program cycle lasts a fixed number of clocks. During that time a busy flag is raised and further program writes are held off. Reads of the flash window return the old contents until the new value lands. A status register records completion and three kinds of failure, and its flags are cleared by writing ones to them. One interrupt line combines the completion flag and the error flags, each side gated by its own enable bit.

Byte address bit 11 picks the register window (1) or the flash window (0). In the flash window, bits 10:3 pick the double-word and bit 2 picks the half. The flash contents start out blank, with every bit set.

Top module: `flash_dw_prog`

## Requirements
- R1: After reset the control register and the status register read as zero, `irq` is low and every flash word reads 0xFFFFFFFF.
- R2: Control sits at address 0x800: bit0 program enable, bit1 completion-interrupt enable, bit2 error-interrupt enable. Status sits at address 0x804: bit0 busy, bit1 done, bit2 not-blank error, bit3 shape error, bit4 lock error. Writing 1 to any of bits 1..4 clears that bit; a flag being set in the same cycle wins over the clear.
- R3: When program enable is 0, writes to the flash window change neither the flash contents nor any flag.
- R4: Two accepted word writes to offsets 0 and 4 of the same aligned double-word start one program cycle. The two writes may come in either order. The word at offset 0 becomes bits 31:0 and the word at offset 4 becomes bits 63:32. When the cycle ends, the done flag is set.
- R5: Busy is high for exactly PROG_CYCLES clocks, starting the cycle after the completing write. During that time a program write sees `bus_ready` low, and flash reads return the old contents. The new value and the done flag appear together when busy drops.
- R6: A program write with `bus_size` other than 2 (0 = byte, 1 = half, 2 = word), or with address bits 1:0 not zero, sets the shape error flag. It programs nothing and discards any stored half.
- R7: A program write to a different double-word than the one holding a stored half sets the shape error flag. Both the stored half and the new write are discarded.
- R8: A lone half that is never paired programs nothing and raises no flag.
- R9: Pairing onto a double-word that is not all ones sets the not-blank error flag and leaves the flash unchanged. This holds even when the new data is all zeros.
- R10: Pairing onto a double-word whose page has its `wp_mask` bit set sets the lock error flag and leaves the flash unchanged. A page is PAGE_DW double-words. The lock check comes before the blank check.
- R11: `irq` is high exactly when (done AND completion enable) OR (any error flag AND error enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Write size: 0 byte, 1 half, 2 word |
| bus_addr | input | ADDR_W | Byte address; MSB selects the register window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted this cycle; low only to stall program writes |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the request |
| wp_mask | input | NUM_PAGES | One lock bit per flash page |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume a requester that holds a stalled write steady until `bus_ready` rises. They also assume that `rst` is high from time zero for a few clocks, and that `wp_mask` changes only between program requests. The stimulus drives every request on the falling edge and keeps it until it has been accepted. It changes the lock mask only while the block is idle, and it never issues a read and a write together, because the bus carries one request at a time.

// File: rtl/flash_dw_pkg.sv
package flash_dw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;

    typedef struct packed {
        logic err_ie;
        logic end_ie;
        logic prog_en;
    } ctrl_t;

    typedef struct packed {
        logic wp;
        logic al;
        logic pg;
        logic done;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic wp;
        logic al;
        logic pg;
    } err_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_STORE,
        ACT_SHAPE,
        ACT_LOCKED,
        ACT_NOT_BLANK,
        ACT_GO
    } asm_act_e;

    function automatic logic is_blank(input logic [63:0] dw);
        return &dw;
    endfunction

    function automatic logic [63:0] join_halves(input logic hi_new,
                                                input logic [31:0] new_w,
                                                input logic [31:0] lo_old,
                                                input logic [31:0] hi_old);
        return hi_new ? {new_w, lo_old} : {hi_old, new_w};
    endfunction

endpackage

// File: rtl/flash_dw_mem.sv
module flash_dw_mem #(
    parameter int DW_AW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DW_AW-1:0] widx,
    input  logic [63:0]      wdata,
    input  logic [DW_AW-1:0] ridx,
    output logic [63:0]      rdata
);
    localparam int DEPTH = 1 << DW_AW;

    logic [63:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (we) begin
            cells[widx] <= wdata;
        end
    end

    assign rdata = cells[ridx];
endmodule

// File: rtl/flash_dw_asm.sv
module flash_dw_asm
    import flash_dw_pkg::*;
#(
    parameter int DW_AW     = 8,
    parameter int PAGE_DW   = 32,
    parameter int NUM_PAGES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_fire,
    input  bus_size_e            wr_size,
    input  logic [1:0]           wr_lsb,
    input  logic                 wr_half,
    input  logic [DW_AW-1:0]     wr_idx,
    input  logic [31:0]          wr_data,
    input  logic [NUM_PAGES-1:0] wp_mask,
    input  logic [63:0]          cur_dw,
    output logic                 start,
    output logic [DW_AW-1:0]     start_idx,
    output logic [63:0]          start_data,
    output err_t                 err_set
);
    localparam int PG_SH = $clog2(PAGE_DW);

    logic [1:0]       have_q;
    logic [DW_AW-1:0] idx_q;
    logic [31:0]      lo_q;
    logic [31:0]      hi_q;

    logic     shape_ok;
    logic     same_dw;
    logic     other_held;
    logic     locked;
    asm_act_e act;

    assign shape_ok   = (wr_size == SZ_WORD) && (wr_lsb == 2'b00);
    assign same_dw    = (have_q == 2'b00) || (idx_q == wr_idx);
    assign other_held = wr_half ? have_q[0] : have_q[1];
    assign locked     = wp_mask[wr_idx[DW_AW-1:PG_SH]];

    always_comb begin
        act = ACT_NONE;
        if (wr_fire) begin
            if (!shape_ok || !same_dw) begin
                act = ACT_SHAPE;
            end else if (!other_held) begin
                act = ACT_STORE;
            end else if (locked) begin
                act = ACT_LOCKED;
            end else if (!is_blank(cur_dw)) begin
                act = ACT_NOT_BLANK;
            end else begin
                act = ACT_GO;
            end
        end
    end

    assign start      = (act == ACT_GO);
    assign start_idx  = wr_idx;
    assign start_data = join_halves(wr_half, wr_data, lo_q, hi_q);
    assign err_set.al = (act == ACT_SHAPE);
    assign err_set.wp = (act == ACT_LOCKED);
    assign err_set.pg = (act == ACT_NOT_BLANK);

    always_ff @(posedge clk) begin
        if (rst) begin
            have_q <= 2'b00;
            idx_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            case (act)
                ACT_STORE: begin
                    have_q[wr_half] <= 1'b1;
                    idx_q           <= wr_idx;
                    if (wr_half) hi_q <= wr_data;
                    else         lo_q <= wr_data;
                end
                ACT_SHAPE, ACT_LOCKED, ACT_NOT_BLANK, ACT_GO: begin
                    have_q <= 2'b00;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/flash_dw_seq.sv
module flash_dw_seq #(
    parameter int DW_AW       = 8,
    parameter int PROG_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW_AW-1:0] start_idx,
    input  logic [63:0]      start_data,
    output logic             busy,
    output logic             mem_we,
    output logic [DW_AW-1:0] mem_idx,
    output logic [63:0]      mem_data,
    output logic             done_set
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last     = busy && (cnt_q == '0);
    assign mem_we   = last;
    assign done_set = last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            mem_idx  <= '0;
            mem_data <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt_q    <= CNT_W'(PROG_CYCLES - 1);
            mem_idx  <= start_idx;
            mem_data <= start_data;
        end else if (busy) begin
            if (last) busy  <= 1'b0;
            else      cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/flash_dw_regs.sv
module flash_dw_regs
    import flash_dw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_sel,
    input  logic [4:0]  reg_wdata,
    input  logic        busy,
    input  logic        done_set,
    input  err_t        err_set,
    output ctrl_t       ctrl,
    output stat_t       stat,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    logic [3:0] clr;
    stat_t      flags_q;

    assign clr = (reg_we && reg_sel) ? reg_wdata[4:1] : 4'b0000;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            flags_q <= '0;
        end else begin
            if (reg_we && !reg_sel) ctrl <= ctrl_t'(reg_wdata[2:0]);
            flags_q.busy <= 1'b0;
            flags_q.done <= (flags_q.done & ~clr[0]) | done_set;
            flags_q.pg   <= (flags_q.pg   & ~clr[1]) | err_set.pg;
            flags_q.al   <= (flags_q.al   & ~clr[2]) | err_set.al;
            flags_q.wp   <= (flags_q.wp   & ~clr[3]) | err_set.wp;
        end
    end

    always_comb begin
        stat      = flags_q;
        stat.busy = busy;
    end

    assign reg_rdata = reg_sel ? {27'd0, stat} : {29'd0, ctrl};
    assign irq = (stat.done & ctrl.end_ie)
               | ((stat.pg | stat.al | stat.wp) & ctrl.err_ie);
endmodule

// File: rtl/flash_dw_prog.sv
module flash_dw_prog
    import flash_dw_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_DW     = 32,
    parameter int PROG_CYCLES = 16,
    parameter int NUM_PAGES   = (1 << (ADDR_W - 4)) / PAGE_DW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [1:0]           bus_size,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_ready,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PAGES-1:0] wp_mask,
    output logic                 irq
);
    localparam int DW_AW = ADDR_W - 4;

    ctrl_t            ctrl;
    stat_t            stat;
    err_t             err_set;
    logic             is_reg;
    logic             fw_req;
    logic             fw_fire;
    logic             reg_we;
    logic             busy;
    logic             start;
    logic [DW_AW-1:0] start_idx;
    logic [63:0]      start_data;
    logic             mem_we;
    logic [DW_AW-1:0] mem_idx;
    logic [63:0]      mem_data;
    logic             done_set;
    logic [DW_AW-1:0] bus_idx;
    logic [63:0]      cur_dw;
    logic [31:0]      reg_rdata;

    assign is_reg    = bus_addr[ADDR_W-1];
    assign bus_idx   = bus_addr[ADDR_W-2:3];
    assign fw_req    = bus_valid && bus_write && !is_reg && ctrl.prog_en;
    assign bus_ready = !(fw_req && busy);
    assign fw_fire   = fw_req && !busy;
    assign reg_we    = bus_valid && bus_write && is_reg;

    flash_dw_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (bus_addr[2]),
        .reg_wdata (bus_wdata[4:0]),
        .busy      (busy),
        .done_set  (done_set),
        .err_set   (err_set),
        .ctrl      (ctrl),
        .stat      (stat),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    flash_dw_asm #(
        .DW_AW     (DW_AW),
        .PAGE_DW   (PAGE_DW),
        .NUM_PAGES (NUM_PAGES)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .wr_fire    (fw_fire),
        .wr_size    (bus_size_e'(bus_size)),
        .wr_lsb     (bus_addr[1:0]),
        .wr_half    (bus_addr[2]),
        .wr_idx     (bus_idx),
        .wr_data    (bus_wdata),
        .wp_mask    (wp_mask),
        .cur_dw     (cur_dw),
        .start      (start),
        .start_idx  (start_idx),
        .start_data (start_data),
        .err_set    (err_set)
    );

    flash_dw_seq #(
        .DW_AW       (DW_AW),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_idx  (start_idx),
        .start_data (start_data),
        .busy       (busy),
        .mem_we     (mem_we),
        .mem_idx    (mem_idx),
        .mem_data   (mem_data),
        .done_set   (done_set)
    );

    flash_dw_mem #(
        .DW_AW (DW_AW)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .widx  (mem_idx),
        .wdata (mem_data),
        .ridx  (bus_idx),
        .rdata (cur_dw)
    );

    assign bus_rdata = is_reg ? reg_rdata : (bus_addr[2] ? cur_dw[63:32] : cur_dw[31:0]);
endmodule

// File: rtl/flash_dw_prog_chk.sv
module flash_dw_prog_chk
    import flash_dw_pkg::*;
#(
    parameter int PROG_CYCLES = 16
) (
    input logic  clk,
    input logic  rst,
    input logic  bus_ready,
    input logic  fw_req,
    input logic  busy,
    input logic  start,
    input err_t  err_set,
    input logic  mem_we,
    input stat_t stat,
    input ctrl_t ctrl,
    input logic  irq
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    a_r5_stall: assert property (@(posedge clk) disable iff (rst)
        (fw_req && busy) |-> !bus_ready);

    a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == PROG_CYCLES));

    a_r5_no_start_when_busy: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    a_r4_commit_inside_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    a_r4_done_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> stat.done);

    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        start |-> ctrl.prog_en);

    a_r9_single_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start, err_set.pg, err_set.al, err_set.wp}));

    a_r11_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.end_ie && !ctrl.err_ie) |-> !irq);
endmodule

bind flash_dw_prog flash_dw_prog_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ready (bus_ready),
    .fw_req    (fw_req),
    .busy      (busy),
    .start     (start),
    .err_set   (err_set),
    .mem_we    (mem_we),
    .stat      (stat),
    .ctrl      (ctrl),
    .irq       (irq)
);

// File: tb/flash_dw_prog_bench.sv
module flash_dw_prog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;
    localparam int PROG       = 16;
    localparam logic [11:0] A_CTRL = 12'h800;
    localparam logic [11:0] A_STAT = 12'h804;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [7:0]  wp_mask = '0;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_dw_prog #(.PROG_CYCLES(PROG)) u_flash_dw_prog (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .wp_mask(wp_mask), .irq(irq)
    );

    // behavioural reference
    logic [63:0] mmem [256];
    bit          m_pen, m_eie, m_iie, m_done, m_pg, m_al, m_wp, m_busy;
    int          m_cnt, m_pidx, m_idx;
    logic [63:0] m_pdata;
    bit  [1:0]   m_have;
    logic [31:0] m_word [2];
    bit          e_fwreq, e_acc, e_reg, s_done, s_pg, s_al, s_wp, e_half;
    bit  [3:0]   e_clr;
    int          e_idx;
    logic [63:0] e_merged;

    always @(posedge clk) begin
        if (rst) begin
            foreach (mmem[i]) mmem[i] = '1;
            {m_pen, m_eie, m_iie, m_done, m_pg, m_al, m_wp, m_busy} = '0;
            m_cnt = 0; m_have = 2'b00;
        end else begin
            e_reg   = bus_addr[11];
            e_fwreq = bus_valid && bus_write && !e_reg && m_pen;
            e_acc   = e_fwreq && !m_busy;
            {s_done, s_pg, s_al, s_wp} = '0;
            e_clr = '0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    mmem[m_pidx] = m_pdata; m_busy = 0; s_done = 1;
                end else m_cnt--;
            end
            if (bus_valid && bus_write && e_reg) begin
                if (!bus_addr[2]) {m_iie, m_eie, m_pen} = bus_wdata[2:0];
                else e_clr = bus_wdata[4:1];
            end
            if (e_acc) begin
                e_idx  = int'(bus_addr[10:3]);
                e_half = bus_addr[2];
                if (bus_size != 2'd2 || bus_addr[1:0] != 2'b00) begin
                    s_al = 1; m_have = 2'b00;
                end else if (m_have != 2'b00 && m_idx != e_idx) begin
                    s_al = 1; m_have = 2'b00;
                end else if (m_have[!e_half]) begin
                    e_merged = e_half ? {bus_wdata, m_word[0]} : {m_word[1], bus_wdata};
                    m_have = 2'b00;
                    if (wp_mask[e_idx/32]) s_wp = 1;
                    else if (mmem[e_idx] != 64'hFFFF_FFFF_FFFF_FFFF) s_pg = 1;
                    else begin
                        m_busy = 1; m_cnt = PROG - 1; m_pidx = e_idx; m_pdata = e_merged;
                    end
                end else begin
                    m_have[e_half] = 1; m_idx = e_idx; m_word[e_half] = bus_wdata;
                end
            end
            m_done = (m_done && !e_clr[0]) || s_done;
            m_pg   = (m_pg   && !e_clr[1]) || s_pg;
            m_al   = (m_al   && !e_clr[2]) || s_al;
            m_wp   = (m_wp   && !e_clr[3]) || s_wp;
        end
    end

    function automatic logic [31:0] model_rdata();
        if (bus_addr[11])
            return bus_addr[2] ? {27'd0, m_wp, m_al, m_pg, m_done, m_busy}
                               : {29'd0, m_iie, m_eie, m_pen};
        return bus_addr[2] ? mmem[bus_addr[10:3]][63:32] : mmem[bus_addr[10:3]][31:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always begin
        @(negedge clk);
        #Q;
        if (!rst) begin
            chk("R11 irq vs model", {31'd0, irq},
                {31'd0, (m_done && m_eie) || ((m_pg || m_al || m_wp) && m_iie)});
            chk("R5 ready vs model", {31'd0, bus_ready},
                {31'd0, !(bus_valid && bus_write && !bus_addr[11] && m_pen && m_busy)});
            if (bus_valid && !bus_write) chk("R2 rdata vs model", bus_rdata, model_rdata());
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input logic [1:0] sz, output int stalls);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
        stalls = 0;
        #Q;
        while (!bus_ready) begin
            stalls++;
            @(negedge clk);
            #Q;
        end
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic w(input logic [11:0] a, input logic [31:0] d);
        int s;
        wr(a, d, 2'd2, s);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #Q;
        d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic expect_rd(input string tag, input logic [11:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int st;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        expect_rd("R1 ctrl reset", A_CTRL, 32'h0);
        expect_rd("R1 stat reset", A_STAT, 32'h0);
        expect_rd("R1 flash blank", 12'h010, 32'hFFFF_FFFF);
        chk("R1 irq low", {31'd0, irq}, 32'h0);

        // R3: program enable off
        w(12'h000, 32'h1111_1111);
        w(12'h004, 32'h2222_2222);
        idle(PROG + 4);
        expect_rd("R3 lo untouched", 12'h000, 32'hFFFF_FFFF);
        expect_rd("R3 hi untouched", 12'h004, 32'hFFFF_FFFF);
        expect_rd("R3 no flags", A_STAT, 32'h0);

        w(A_CTRL, 32'h3);
        expect_rd("R2 ctrl readback", A_CTRL, 32'h3);

        // R4/R5: low then high, then a stalled write
        w(12'h008, 32'hA5A5_0001);
        w(12'h00C, 32'h5A5A_0002);
        wr(12'h010, 32'h0000_0AAA, 2'd2, st);
        chk("R5 stall cycles", st, PROG - 1);
        expect_rd("R4 low word", 12'h008, 32'hA5A5_0001);
        expect_rd("R4 high word", 12'h00C, 32'h5A5A_0002);
        expect_rd("R4 done flag", A_STAT, 32'h2);
        chk("R11 end irq", {31'd0, irq}, 32'h1);

        w(12'h014, 32'h0000_0BBB);
        expect_rd("R5 busy visible", A_STAT, 32'h3);
        expect_rd("R5 old contents", 12'h010, 32'hFFFF_FFFF);
        idle(PROG + 4);
        expect_rd("R4 dw2 low", 12'h010, 32'h0000_0AAA);
        expect_rd("R4 dw2 high", 12'h014, 32'h0000_0BBB);

        // R4: high half first
        w(12'h01C, 32'h3333_4444);
        w(12'h018, 32'h1111_2222);
        idle(PROG + 4);
        expect_rd("R4 reversed low", 12'h018, 32'h1111_2222);
        expect_rd("R4 reversed high", 12'h01C, 32'h3333_4444);

        w(A_STAT, 32'h1E);
        expect_rd("R2 w1c clears", A_STAT, 32'h0);
        chk("R11 irq after clear", {31'd0, irq}, 32'h0);

        // R8: lone half
        w(12'h020, 32'h0000_1234);
        idle(PROG + 4);
        expect_rd("R8 nothing written", 12'h020, 32'hFFFF_FFFF);
        expect_rd("R8 no flag", A_STAT, 32'h0);

        // R7: different double-word while a half is held
        w(12'h02C, 32'h0000_5678);
        expect_rd("R7 shape flag", A_STAT, 32'h8);
        w(12'h024, 32'h0000_9999);
        idle(PROG + 4);
        expect_rd("R7 held half dropped", 12'h020, 32'hFFFF_FFFF);

        // R6: narrow and misaligned writes (also drops the half from 0x024)
        w(A_STAT, 32'h1E);
        wr(12'h030, 32'h0000_00AB, 2'd0, st);
        expect_rd("R6 byte write", A_STAT, 32'h8);
        w(A_STAT, 32'h1E);
        wr(12'h031, 32'h0000_00AB, 2'd2, st);
        expect_rd("R6 misaligned word", A_STAT, 32'h8);
        expect_rd("R6 flash unchanged", 12'h030, 32'hFFFF_FFFF);
        w(A_STAT, 32'h1E);

        // R9: double-word already written
        w(12'h008, 32'h0);
        w(12'h00C, 32'h0);
        expect_rd("R9 not-blank flag", A_STAT, 32'h4);
        expect_rd("R9 contents kept", 12'h008, 32'hA5A5_0001);
        w(A_STAT, 32'h1E);

        // R10: locked page, and lock checked before blank
        w(12'h108, 32'h0F0F_0F0F);
        w(12'h10C, 32'hF0F0_F0F0);
        idle(PROG + 4);
        w(A_STAT, 32'h1E);
        @(negedge clk) wp_mask = 8'b0000_0010;
        w(12'h100, 32'h0000_0001);
        w(12'h104, 32'h0000_0002);
        expect_rd("R10 lock flag", A_STAT, 32'h10);
        expect_rd("R10 flash unchanged", 12'h100, 32'hFFFF_FFFF);
        w(A_STAT, 32'h1E);
        w(12'h108, 32'h0);
        w(12'h10C, 32'h0);
        expect_rd("R10 lock before blank", A_STAT, 32'h10);

        // R11: error interrupt only
        w(A_CTRL, 32'h4);
        chk("R11 error irq", {31'd0, irq}, 32'h1);
        w(A_STAT, 32'h1E);
        chk("R11 error irq cleared", {31'd0, irq}, 32'h0);

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule